// File: doc/BRIEF.md
# Sleep Wake-up and Event Logic

This block decides when a sleeping core resumes. A sleep request puts it into one of two sleep kinds. Interrupt sleep ends only when some interrupt line would win on priority. Event sleep ends on that same interrupt condition or on any event. The block keeps the one-bit event flag that event sleep consumes. Events come from an external input, from a software event strobe and, when the send-on-pending control bit is set, from any interrupt line that newly becomes pending.

The global interrupt mask plays no part in the wake decision. A masked but otherwise eligible interrupt still wakes the core. It is reported with a distinct cause code, so the core resumes after the sleep instruction and the interrupt stays pending. The block does not arbitrate or dispatch interrupts. It only evaluates wake conditions and reports a registered one-cycle wake pulse with its cause.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `asleep`, `wake`, `evt_flag` and `wake_cause` are all 0.
- R2: A `sleep_req` pulse while awake sets `asleep` on the next clock edge. `sleep_kind` 0 selects interrupt sleep, and 1 selects event sleep, which enters only when `evt_flag` is 0.
- R3: A line is eligible when it is pending, enabled, and its priority is numerically below the threshold (a lower number is more urgent). The threshold is `exec_prio`, or `mask_lvl` when `mask_lvl` is nonzero and smaller. An `exec_prio` of 2^PRIO_W means no handler is active. Line i's priority is `line_prio[i*PRIO_W +: PRIO_W]`.
- R4: In either sleep kind, an eligible line makes `wake` high for exactly one cycle, one clock edge after the condition appears. `asleep` clears on that same edge.
- R5: `gmask` never blocks a wake. `wake_cause` is 1 (entry) when `gmask` is 0 and 2 (held pending) when it is 1. `wake_cause` is 0 whenever `wake` is low.
- R6: `ext_evt`, `sw_evt`, or (with `sev_on_pend` set) a 0-to-1 change of any pending bit, enabled or not, sets `evt_flag` on the next edge.
- R7: A pending bit that stays high makes no further event. With `sev_on_pend` clear, a new pending bit makes no event.
- R8: Event sleep wakes when an event is latched or arriving, with `wake_cause` 3, and `evt_flag` is 0 after the wake. When an eligible interrupt is present at the same time, its cause (1 or 2) is reported instead.
- R9: An event-sleep request while `evt_flag` is 1 clears `evt_flag` and leaves `asleep` and `wake` low.
- R10: Events never wake interrupt sleep, but they still set `evt_flag`.
- R11: A `sleep_req` while asleep is ignored and does not change the sleep kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Sleep instruction strobe |
| sleep_kind | input | 1 | 0 interrupt sleep, 1 event sleep |
| line_pend | input | N_LINES | Pending bits per line |
| line_en | input | N_LINES | Enable bits per line |
| line_prio | input | N_LINES*PRIO_W | Packed priority per line |
| exec_prio | input | PRIO_W+1 | Current execution priority |
| mask_lvl | input | PRIO_W | Priority mask level, 0 = off |
| gmask | input | 1 | Global interrupt mask |
| sev_on_pend | input | 1 | New pending bit raises an event |
| ext_evt | input | 1 | External event pulse |
| sw_evt | input | 1 | Software event pulse |
| asleep | output | 1 | Core is sleeping |
| wake | output | 1 | One-cycle wake pulse |
| wake_cause | output | 2 | 0 none, 1 entry, 2 held, 3 event |
| evt_flag | output | 1 | Latched event flag |

## Verification
Interrupt sleep is tried with lines that are disabled, that have equal or lower priority than the threshold, that are cut off by the mask level, and that are fully eligible. Together these separate the strict priority comparison from the enable and mask-level terms. The global mask is toggled on an eligible line to tell the held cause from the entry cause. Event sleep is tried with external and software events, with new pending edges on disabled lines with the send-on-pending bit on and off, and with a line held pending. This shows that only edges make events. A request made while the flag is already set shows the skip path.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_ENTRY = 2'd1,
    CAUSE_HELD  = 2'd2,
    CAUSE_EVENT = 2'd3
  } cause_e;

  localparam logic KIND_IRQ = 1'b0;
  localparam logic KIND_EVT = 1'b1;
endpackage

// File: rtl/swc_irq_gate.sv
module swc_irq_gate #(
  parameter int N_LINES = 8,
  parameter int PRIO_W  = 3
) (
  input  logic [N_LINES-1:0]        line_pend,
  input  logic [N_LINES-1:0]        line_en,
  input  logic [N_LINES*PRIO_W-1:0] line_prio,
  input  logic [PRIO_W:0]           exec_prio,
  input  logic [PRIO_W-1:0]         mask_lvl,
  output logic                      any_ok
);
  localparam int TW = PRIO_W + 1;

  logic [TW-1:0]      thr;
  logic [N_LINES-1:0] ok;

  // The mask level only tightens the threshold, never loosens it.
  always_comb begin
    if (mask_lvl != '0 && {1'b0, mask_lvl} < exec_prio)
      thr = {1'b0, mask_lvl};
    else
      thr = exec_prio;
  end

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    assign ok[i] = line_pend[i] & line_en[i] &
                   ({1'b0, line_prio[i*PRIO_W +: PRIO_W]} < thr);
  end

  assign any_ok = |ok;
endmodule

// File: rtl/swc_evt_latch.sv
module swc_evt_latch #(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] line_pend,
  input  logic               sev_on_pend,
  input  logic               ext_evt,
  input  logic               sw_evt,
  input  logic               clr_all,
  input  logic               clr_reg,
  output logic               evt_in,
  output logic               evt_q
);
  logic [N_LINES-1:0] pend_q;
  logic               new_pend;

  assign new_pend = |(line_pend & ~pend_q);
  assign evt_in   = ext_evt | sw_evt | (sev_on_pend & new_pend);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      evt_q  <= 1'b0;
    end else begin
      pend_q <= line_pend;
      if (clr_all)
        evt_q <= 1'b0;
      else
        evt_q <= evt_in | (evt_q & ~clr_reg);
    end
  end
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import swc_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int PRIO_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sleep_req,
  input  logic                      sleep_kind,
  input  logic [N_LINES-1:0]        line_pend,
  input  logic [N_LINES-1:0]        line_en,
  input  logic [N_LINES*PRIO_W-1:0] line_prio,
  input  logic [PRIO_W:0]           exec_prio,
  input  logic [PRIO_W-1:0]         mask_lvl,
  input  logic                      gmask,
  input  logic                      sev_on_pend,
  input  logic                      ext_evt,
  input  logic                      sw_evt,
  output logic                      asleep,
  output logic                      wake,
  output logic [1:0]                wake_cause,
  output logic                      evt_flag
);
  logic   irq_ok, evt_in, evt_q;
  logic   asleep_q, kind_q, wake_q;
  cause_e cause_q, cause_d;
  logic   wake_irq, wake_evt, wake_now, skip, clr_all;

  swc_irq_gate #(.N_LINES(N_LINES), .PRIO_W(PRIO_W)) u_gate (
    .line_pend (line_pend),
    .line_en   (line_en),
    .line_prio (line_prio),
    .exec_prio (exec_prio),
    .mask_lvl  (mask_lvl),
    .any_ok    (irq_ok)
  );

  swc_evt_latch #(.N_LINES(N_LINES)) u_evt (
    .clk         (clk),
    .rst         (rst),
    .line_pend   (line_pend),
    .sev_on_pend (sev_on_pend),
    .ext_evt     (ext_evt),
    .sw_evt      (sw_evt),
    .clr_all     (clr_all),
    .clr_reg     (skip),
    .evt_in      (evt_in),
    .evt_q       (evt_q)
  );

  assign wake_irq = asleep_q & irq_ok;
  assign wake_evt = asleep_q & (kind_q == KIND_EVT) & (evt_q | evt_in);
  assign wake_now = wake_irq | wake_evt;
  assign skip     = sleep_req & ~asleep_q & (sleep_kind == KIND_EVT) & evt_q;
  assign clr_all  = asleep_q & (kind_q == KIND_EVT) & wake_now;

  always_comb begin
    if (!wake_now)     cause_d = CAUSE_NONE;
    else if (wake_irq) cause_d = gmask ? CAUSE_HELD : CAUSE_ENTRY;
    else               cause_d = CAUSE_EVENT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      asleep_q <= 1'b0;
      kind_q   <= KIND_IRQ;
      wake_q   <= 1'b0;
      cause_q  <= CAUSE_NONE;
    end else begin
      wake_q  <= wake_now;
      cause_q <= cause_d;
      if (wake_now) begin
        asleep_q <= 1'b0;
      end else if (sleep_req && !asleep_q && !skip) begin
        asleep_q <= 1'b1;
        kind_q   <= sleep_kind;
      end
    end
  end

  assign asleep     = asleep_q;
  assign wake       = wake_q;
  assign wake_cause = cause_q;
  assign evt_flag   = evt_q;
endmodule

// File: rtl/sleep_wake_ctrl_chk.sv
module sleep_wake_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       sleep_req,
  input logic       sleep_kind,
  input logic       ext_evt,
  input logic       sw_evt,
  input logic       sev_on_pend,
  input logic       asleep,
  input logic       wake,
  input logic [1:0] wake_cause,
  input logic       evt_flag
);
  // R4
  wake_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    wake |=> !wake);

  // R4
  wake_from_sleep_chk: assert property (@(posedge clk) disable iff (rst)
    wake |-> ($past(asleep) && !asleep));

  // R5
  cause_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !wake |-> (wake_cause == 2'd0));

  // R2
  irq_sleep_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (sleep_req && !sleep_kind && !asleep) |=> asleep);

  // R6
  evt_latch_chk: assert property (@(posedge clk) disable iff (rst)
    ((ext_evt || sw_evt) && !asleep) |=> evt_flag);

  // R9
  evt_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (sleep_req && sleep_kind && !asleep && evt_flag && !ext_evt && !sw_evt && !sev_on_pend)
      |=> (!asleep && !evt_flag && !wake));
endmodule

bind sleep_wake_ctrl sleep_wake_ctrl_chk u_chk (.*);

// File: tb/sleep_wake_ctrl_test.sv
`timescale 1ns/1ps
module sleep_wake_ctrl_test;
  localparam int N  = 8;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          sleep_req, sleep_kind;
  logic [N-1:0]  line_pend, line_en;
  logic [N*PW-1:0] line_prio;
  logic [PW:0]   exec_prio;
  logic [PW-1:0] mask_lvl;
  logic          gmask, sev_on_pend, ext_evt, sw_evt;
  logic          asleep, wake, evt_flag;
  logic [1:0]    wake_cause;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  sleep_wake_ctrl #(.N_LINES(N), .PRIO_W(PW)) uut (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .sleep_kind(sleep_kind),
    .line_pend(line_pend), .line_en(line_en), .line_prio(line_prio),
    .exec_prio(exec_prio), .mask_lvl(mask_lvl), .gmask(gmask),
    .sev_on_pend(sev_on_pend), .ext_evt(ext_evt), .sw_evt(sw_evt),
    .asleep(asleep), .wake(wake), .wake_cause(wake_cause), .evt_flag(evt_flag)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clean();
    rst = 1'b1; sleep_req = 0; sleep_kind = 0;
    line_pend = '0; line_en = '0; line_prio = '0;
    exec_prio = 4'd8; mask_lvl = '0; gmask = 0;
    sev_on_pend = 0; ext_evt = 0; sw_evt = 0;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic set_line(int i, bit p, bit e, int pr);
    line_pend[i] = p;
    line_en[i]   = e;
    line_prio[i*PW +: PW] = pr[PW-1:0];
  endtask

  task automatic go_sleep(bit kind);
    sleep_req = 1; sleep_kind = kind;
    step();
    sleep_req = 0;
  endtask

  task automatic t_reset();
    clean();
    rst = 1'b1; ext_evt = 1; sw_evt = 1; sleep_req = 1;
    step();
    chk("R1", "asleep in reset", asleep, 0);
    chk("R1", "evt in reset", evt_flag, 0);
    ext_evt = 0; sw_evt = 0; sleep_req = 0; rst = 1'b0;
    step();
    chk("R1", "wake after reset", wake, 0);
    chk("R1", "cause after reset", wake_cause, 0);
    chk("R1", "evt after reset", evt_flag, 0);
  endtask

  task automatic t_irq_wake();
    clean();
    go_sleep(0);
    chk("R2", "asleep after request", asleep, 1);
    set_line(2, 1, 1, 1);
    step();
    chk("R4", "wake pulse", wake, 1);
    chk("R4", "asleep cleared", asleep, 0);
    chk("R5", "entry cause", wake_cause, 1);
    step();
    chk("R4", "wake drops", wake, 0);
  endtask

  task automatic t_prio_block();
    clean();
    exec_prio = 4'd2;
    set_line(3, 1, 1, 2);
    go_sleep(0);
    step(); step();
    chk("R3", "equal prio no wake", wake, 0);
    chk("R3", "still asleep", asleep, 1);
    exec_prio = 4'd3;
    step();
    chk("R3", "raised threshold wakes", wake, 1);
  endtask

  task automatic t_mask_and_enable();
    clean();
    mask_lvl = 3'd2;
    set_line(1, 1, 1, 2);
    set_line(4, 1, 0, 0);
    go_sleep(0);
    step(); step();
    chk("R3", "mask level blocks", wake, 0);
    chk("R3", "disabled line no wake", asleep, 1);
    line_prio[1*PW +: PW] = 3'd1;
    step();
    chk("R3", "under mask level wakes", wake, 1);
  endtask

  task automatic t_gmask();
    clean();
    gmask = 1;
    go_sleep(0);
    set_line(0, 1, 1, 5);
    step();
    chk("R5", "masked wake", wake, 1);
    chk("R5", "held cause", wake_cause, 2);
  endtask

  task automatic t_irq_sleep_events();
    clean();
    go_sleep(0);
    ext_evt = 1;
    step();
    ext_evt = 0;
    chk("R10", "event latched", evt_flag, 1);
    step(); step();
    chk("R10", "no wake on event", wake, 0);
    chk("R10", "still asleep", asleep, 1);
    sleep_req = 1; sleep_kind = 1;
    step();
    sleep_req = 0;
    step();
    chk("R11", "request while asleep ignored", asleep, 1);
    chk("R11", "kind unchanged", wake, 0);
  endtask

  task automatic t_evt_skip();
    clean();
    sw_evt = 1;
    step();
    sw_evt = 0;
    chk("R6", "software event latched", evt_flag, 1);
    go_sleep(1);
    chk("R9", "no sleep", asleep, 0);
    chk("R9", "flag consumed", evt_flag, 0);
    chk("R9", "no wake", wake, 0);
  endtask

  task automatic t_evt_wake();
    clean();
    go_sleep(1);
    chk("R2", "event sleep entered", asleep, 1);
    step();
    chk("R8", "no spurious wake", wake, 0);
    ext_evt = 1;
    step();
    ext_evt = 0;
    chk("R8", "event wake", wake, 1);
    chk("R8", "event cause", wake_cause, 3);
    chk("R8", "flag cleared", evt_flag, 0);
    go_sleep(1);
    set_line(6, 1, 1, 0);
    sw_evt = 1;
    step();
    sw_evt = 0;
    chk("R8", "irq wins cause", wake_cause, 1);
  endtask

  task automatic t_sev_on_pend();
    clean();
    set_line(5, 1, 0, 7);
    step();
    chk("R7", "no event without control bit", evt_flag, 0);
    line_pend[5] = 0;
    step();
    sev_on_pend = 1;
    go_sleep(1);
    line_pend[5] = 1;
    step();
    chk("R6", "new pending wakes", wake, 1);
    chk("R6", "event cause", wake_cause, 3);
    go_sleep(1);
    step(); step();
    chk("R7", "held pending no wake", wake, 0);
    chk("R7", "held pending no flag", evt_flag, 0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_irq_wake();
    t_prio_block();
    t_mask_and_enable();
    t_gmask();
    t_irq_sleep_events();
    t_evt_skip();
    t_evt_wake();
    t_sev_on_pend();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule